// File: doc/BRIEF.md
# Triggered Single-Unit Transfer Engine

This block is a four-channel transfer engine. Each trigger pulse moves exactly one data unit on a simple synchronous 16-bit memory bus. Every channel holds four registers: a source pointer, a destination pointer, a remaining-count value and an operating-mode byte. Software writes these registers through a single write port. Software does not read them back. Their effect shows on the bus and on the pulse outputs.

When a channel is triggered, the engine reads one unit at the source pointer and writes it at the destination pointer. The unit is a byte, a 16-bit word or a 4-byte quantity. The engine then steps one pointer, as the mode selects, and decrements the count. When the count reaches zero, the channel raises a one-cycle terminal-count pulse. A counting mode does no bus access. It only advances the source pointer, so the engine can count events. Busy time is fixed for each mode and size. Triggers that arrive while the engine is busy are held, one per channel, and are served with channel 0 first.

Top module: `udma_engine`

## Requirements
- R1: A register write occurs when `cfg_we_i` is high at a clock edge. `cfg_ch_i` picks the channel. `cfg_sel_i` picks the register: 0 = source pointer, 1 = destination pointer, 2 = count (low 16 bits of `cfg_wdata_i`), 3 = mode (low 8 bits).
- R2: The mode byte is laid out as follows. Bits [1:0] are the size: 0 = byte, 1 = word, 2 = 4-byte. Bits [4:2] are the operation: 0 = step destination up, 1 = step destination down, 2 = step source up, 3 = step source down, 4 = fixed, 5 = count only. Bits [7:5] must be zero.
- R3: A data operation reads the source address and then writes the destination address. Bus read data returns in the cycle after the read request. A word write carries the word that was read, with `bus_be_o`=11. A byte write takes the byte lane given by bit 0 of the source, places the byte in both halves of `bus_wdata_o`, and enables lane 01 for an even destination or lane 10 for an odd one.
- R4: A 4-byte operation issues two reads, at the source and at source+2, and then two writes, at the destination and at destination+2. The lower half goes first in each pair.
- R5: Each access uses the pointer's current value. After the operation, the pointer named by the operation moves up or down by 1, 2 or 4 for byte, word or 4-byte. Fixed mode leaves both pointers unchanged.
- R6: Count-only mode makes no bus request. It adds 1 to the source pointer and decrements the count.
- R7: Every accepted operation decrements the count by 1. When the count goes from 1 to 0, the channel's bit of `tc_o` is high for exactly one cycle: the first cycle after busy falls.
- R8: A trigger on a channel whose count is 0 is dropped. It causes no busy time, no bus access and no pulse.
- R9: A non-zero count with an invalid mode byte causes a one-cycle pulse on the channel's `err_o` bit. Invalid means operation 6 or 7, size 3, or any of bits [7:5] set. There is then no busy time and no bus access, and the count is left unchanged.
- R10: `busy_o` is high for exactly 8 cycles for a byte or word operation, 12 cycles for a 4-byte operation and 5 cycles for count-only. When the engine is idle, busy starts in the cycle after the trigger edge.
- R11: Each channel holds at most one pending trigger. Repeated triggers merge into one. When several channels are eligible in the same cycle, the lowest-numbered channel goes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_ch_i | input | 2 | Channel selected for the write |
| cfg_sel_i | input | 2 | Register selected for the write |
| cfg_wdata_i | input | 24 | Write data |
| trig_i | input | 4 | One-cycle trigger per channel |
| busy_o | output | 1 | Engine busy with an operation |
| tc_o | output | 4 | Terminal-count pulse per channel |
| err_o | output | 4 | Invalid-mode pulse per channel |
| bus_req_o | output | 1 | Bus access request |
| bus_we_o | output | 1 | Bus write (1) or read (0) |
| bus_addr_o | output | 24 | Bus byte address |
| bus_be_o | output | 2 | Byte-lane enables |
| bus_wdata_o | output | 16 | Bus write data |
| bus_rdata_i | input | 16 | Bus read data, one cycle after the read request |

## Verification
Trigger arrival and arbitration can fall in the same cycle. This happens when several channels fire on one edge, or when new triggers land while an operation is still running. The bench drives simultaneous triggers while the engine is idle, and staggered triggers on several channels during a busy window, including a repeated trigger on one channel. It then judges the order and the number of served operations from the sequence of read addresses seen on the bus. Constrained-random operations across all modes and sizes are checked against bench-computed busy lengths, addresses, data lanes and pointer steps.

// File: rtl/udma_pkg.sv
`timescale 1ns/1ps
package udma_pkg;
  localparam logic [2:0] OP_DST_INC = 3'd0;
  localparam logic [2:0] OP_DST_DEC = 3'd1;
  localparam logic [2:0] OP_SRC_INC = 3'd2;
  localparam logic [2:0] OP_SRC_DEC = 3'd3;
  localparam logic [2:0] OP_FIXED   = 3'd4;
  localparam logic [2:0] OP_COUNT   = 3'd5;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
  localparam logic [1:0] SZ_QUAD = 2'd2;

  localparam int unsigned LEN_W = 4;
  localparam logic [LEN_W-1:0] LEN_SHORT = 4'd8;
  localparam logic [LEN_W-1:0] LEN_QUAD  = 4'd12;
  localparam logic [LEN_W-1:0] LEN_COUNT = 4'd5;

  typedef struct packed {
    logic [2:0] zero;
    logic [2:0] op;
    logic [1:0] size;
  } mode_t;

  function automatic logic mode_ok(mode_t m);
    return (m.zero == 3'b000) && (m.op <= OP_COUNT) && (m.size != 2'd3);
  endfunction

  function automatic logic [LEN_W-1:0] run_len(mode_t m);
    if (m.op == OP_COUNT) return LEN_COUNT;
    if (m.size == SZ_QUAD) return LEN_QUAD;
    return LEN_SHORT;
  endfunction
endpackage

// File: rtl/udma_chan_regs.sv
`timescale 1ns/1ps
module udma_chan_regs
  import udma_pkg::*;
#(
  parameter int unsigned AW = 24,
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_sel_i,
  input  logic [AW-1:0] cfg_wdata_i,
  input  logic          upd_i,
  input  logic [AW-1:0] upd_src_i,
  input  logic [AW-1:0] upd_dst_i,
  input  logic [CW-1:0] upd_cnt_i,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [CW-1:0] cnt_o,
  output mode_t         mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_o  <= '0;
      dst_o  <= '0;
      cnt_o  <= '0;
      mode_o <= '0;
    end else begin
      if (upd_i) begin
        src_o <= upd_src_i;
        dst_o <= upd_dst_i;
        cnt_o <= upd_cnt_i;
      end
      // software write to the same register wins over the engine update
      if (cfg_we_i) begin
        unique case (cfg_sel_i)
          2'd0: src_o  <= cfg_wdata_i;
          2'd1: dst_o  <= cfg_wdata_i;
          2'd2: cnt_o  <= cfg_wdata_i[CW-1:0];
          default: mode_o <= mode_t'(cfg_wdata_i[7:0]);
        endcase
      end
    end
  end
endmodule

// File: rtl/udma_arb.sv
`timescale 1ns/1ps
module udma_arb #(
  parameter int unsigned NCH = 4,
  localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] trig_i,
  input  logic           take_i,
  output logic           gnt_valid_o,
  output logic [CHW-1:0] gnt_idx_o
);
  logic [NCH-1:0] pend_q, elig, gnt_oh, take_mask;

  assign elig        = pend_q | trig_i;
  assign gnt_valid_o = |elig;
  assign take_mask   = take_i ? gnt_oh : '0;

  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    gnt_oh    = '0;
    gnt_idx_o = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (elig[i]) begin
        gnt_oh    = '0;
        gnt_oh[i] = 1'b1;
        gnt_idx_o = CHW'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= elig & ~take_mask;
  end

  // R11: a pending trigger is never lost unless it was consumed
  assert_pend_kept_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pend_q) |=> ((($past(pend_q) & ~$past(take_mask)) & ~pend_q) == '0));
endmodule

// File: rtl/udma_seq.sv
`timescale 1ns/1ps
module udma_seq
  import udma_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned AW  = 24,
  parameter int unsigned CW  = 16,
  localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_valid_i,
  input  logic [CHW-1:0] req_ch_i,
  input  logic [AW-1:0]  src_i,
  input  logic [AW-1:0]  dst_i,
  input  logic [CW-1:0]  cnt_i,
  input  mode_t          mode_i,
  output logic           take_o,
  output logic           upd_o,
  output logic [CHW-1:0] upd_ch_o,
  output logic [AW-1:0]  upd_src_o,
  output logic [AW-1:0]  upd_dst_o,
  output logic [CW-1:0]  upd_cnt_o,
  output logic           busy_o,
  output logic [NCH-1:0] tc_o,
  output logic [NCH-1:0] err_o,
  output logic           bus_req_o,
  output logic           bus_we_o,
  output logic [AW-1:0]  bus_addr_o,
  output logic [1:0]     bus_be_o,
  output logic [15:0]    bus_wdata_o,
  input  logic [15:0]    bus_rdata_i
);
  typedef enum logic {ST_IDLE, ST_RUN} st_e;

  st_e              st_q;
  logic [CHW-1:0]   ch_q;
  logic [AW-1:0]    src_q, dst_q, step;
  logic [CW-1:0]    cnt_q;
  logic [2:0]       op_q;
  logic [1:0]       sz_q;
  logic [LEN_W-1:0] len_q, k_q;
  logic [15:0]      lo_q, hi_q;
  logic [NCH-1:0]   tc_q, err_q;
  logic             run, is_quad, moves, rd0, rd1, wr0, wr1;
  logic [7:0]       bval;

  assign run     = (st_q == ST_RUN);
  assign busy_o  = run;
  assign take_o  = (st_q == ST_IDLE) && req_valid_i;
  assign upd_o   = run && (k_q == len_q - 4'd1);
  assign tc_o    = tc_q;
  assign err_o   = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      ch_q  <= '0;
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
      op_q  <= '0;
      sz_q  <= '0;
      len_q <= '0;
      k_q   <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
      tc_q  <= '0;
      err_q <= '0;
    end else begin
      tc_q  <= '0;
      err_q <= '0;
      if (st_q == ST_IDLE) begin
        if (take_o && (cnt_i != '0)) begin
          if (mode_ok(mode_i)) begin
            st_q  <= ST_RUN;
            ch_q  <= req_ch_i;
            src_q <= src_i;
            dst_q <= dst_i;
            cnt_q <= cnt_i;
            op_q  <= mode_i.op;
            sz_q  <= mode_i.size;
            len_q <= run_len(mode_i);
            k_q   <= '0;
          end else begin
            err_q[req_ch_i] <= 1'b1;
          end
        end
      end else begin
        k_q <= k_q + 4'd1;
        if (k_q == 4'd1) lo_q <= bus_rdata_i;
        if (k_q == 4'd2) hi_q <= bus_rdata_i;
        if (upd_o) begin
          st_q <= ST_IDLE;
          if (cnt_q == CW'(1)) tc_q[ch_q] <= 1'b1;
        end
      end
    end
  end

  // post-operation pointer and count values
  always_comb begin
    unique case (sz_q)
      SZ_BYTE: step = AW'(1);
      SZ_WORD: step = AW'(2);
      default: step = AW'(4);
    endcase
    upd_ch_o  = ch_q;
    upd_src_o = src_q;
    upd_dst_o = dst_q;
    upd_cnt_o = cnt_q - CW'(1);
    unique case (op_q)
      OP_DST_INC: upd_dst_o = dst_q + step;
      OP_DST_DEC: upd_dst_o = dst_q - step;
      OP_SRC_INC: upd_src_o = src_q + step;
      OP_SRC_DEC: upd_src_o = src_q - step;
      OP_COUNT:   upd_src_o = src_q + AW'(1);
      default: ;
    endcase
  end

  // fixed beat schedule: reads at k0/k1, writes at k3/k4
  assign is_quad = (sz_q == SZ_QUAD);
  assign moves   = run && (op_q != OP_COUNT);
  assign rd0     = (k_q == 4'd0);
  assign rd1     = (k_q == 4'd1) && is_quad;
  assign wr0     = (k_q == 4'd3);
  assign wr1     = (k_q == 4'd4) && is_quad;
  assign bval    = src_q[0] ? lo_q[15:8] : lo_q[7:0];

  assign bus_req_o  = moves && (rd0 || rd1 || wr0 || wr1);
  assign bus_we_o   = moves && (wr0 || wr1);
  assign bus_addr_o = (wr0 || wr1) ? (dst_q + (wr1 ? AW'(2) : AW'(0)))
                                   : (src_q + (rd1 ? AW'(2) : AW'(0)));
  assign bus_wdata_o = wr1 ? hi_q : ((sz_q == SZ_BYTE) ? {bval, bval} : lo_q);
  assign bus_be_o    = (sz_q == SZ_BYTE) ? (bus_addr_o[0] ? 2'b10 : 2'b01) : 2'b11;

  // R10: busy ends right after the register update cycle
  assert_end_after_update_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |=> !busy_o);
  // R8: an operation only starts from a non-zero count
  assert_start_nonzero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(cnt_i) != '0));
  // R7: terminal-count is a single-cycle pulse
  assert_tc_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|tc_q) |=> (tc_q == '0));
  // R7: terminal-count follows an update
  assert_tc_after_update_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|tc_q) |-> $past(upd_o));
  // R9: an error never starts an operation
  assert_err_no_run_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|err_q) |-> !busy_o);
endmodule

// File: rtl/udma_engine.sv
`timescale 1ns/1ps
module udma_engine
  import udma_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned AW  = 24,
  parameter int unsigned CW  = 16,
  localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cfg_we_i,
  input  logic [CHW-1:0] cfg_ch_i,
  input  logic [1:0]     cfg_sel_i,
  input  logic [AW-1:0]  cfg_wdata_i,
  input  logic [NCH-1:0] trig_i,
  output logic           busy_o,
  output logic [NCH-1:0] tc_o,
  output logic [NCH-1:0] err_o,
  output logic           bus_req_o,
  output logic           bus_we_o,
  output logic [AW-1:0]  bus_addr_o,
  output logic [1:0]     bus_be_o,
  output logic [15:0]    bus_wdata_o,
  input  logic [15:0]    bus_rdata_i
);
  logic [AW-1:0]  src_a [NCH];
  logic [AW-1:0]  dst_a [NCH];
  logic [CW-1:0]  cnt_a [NCH];
  mode_t          mode_a [NCH];

  logic           gnt_valid, take, upd;
  logic [CHW-1:0] gnt_idx, upd_ch;
  logic [AW-1:0]  upd_src, upd_dst;
  logic [CW-1:0]  upd_cnt;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    udma_chan_regs #(.AW(AW), .CW(CW)) u_regs (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cfg_we_i    (cfg_we_i && (cfg_ch_i == CHW'(c))),
      .cfg_sel_i   (cfg_sel_i),
      .cfg_wdata_i (cfg_wdata_i),
      .upd_i       (upd && (upd_ch == CHW'(c))),
      .upd_src_i   (upd_src),
      .upd_dst_i   (upd_dst),
      .upd_cnt_i   (upd_cnt),
      .src_o       (src_a[c]),
      .dst_o       (dst_a[c]),
      .cnt_o       (cnt_a[c]),
      .mode_o      (mode_a[c])
    );
  end

  udma_arb #(.NCH(NCH)) u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trig_i      (trig_i),
    .take_i      (take),
    .gnt_valid_o (gnt_valid),
    .gnt_idx_o   (gnt_idx)
  );

  udma_seq #(.NCH(NCH), .AW(AW), .CW(CW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (gnt_valid),
    .req_ch_i    (gnt_idx),
    .src_i       (src_a[gnt_idx]),
    .dst_i       (dst_a[gnt_idx]),
    .cnt_i       (cnt_a[gnt_idx]),
    .mode_i      (mode_a[gnt_idx]),
    .take_o      (take),
    .upd_o       (upd),
    .upd_ch_o    (upd_ch),
    .upd_src_o   (upd_src),
    .upd_dst_o   (upd_dst),
    .upd_cnt_o   (upd_cnt),
    .busy_o      (busy_o),
    .tc_o        (tc_o),
    .err_o       (err_o),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .bus_be_o    (bus_be_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_rdata_i (bus_rdata_i)
  );
endmodule

// File: tb/udma_engine_test.sv
`timescale 1ns/1ps
module udma_engine_test;
  localparam int AW = 24;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [1:0]    cfg_ch_i = '0;
  logic [1:0]    cfg_sel_i = '0;
  logic [AW-1:0] cfg_wdata_i = '0;
  logic [3:0]    trig_i = '0;
  logic          busy_o, bus_req_o, bus_we_o;
  logic [3:0]    tc_o, err_o;
  logic [AW-1:0] bus_addr_o;
  logic [1:0]    bus_be_o;
  logic [15:0]   bus_wdata_o;
  logic [15:0]   rdata;

  always #2 clk_i = ~clk_i;

  udma_engine uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_ch_i(cfg_ch_i),
    .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i), .trig_i(trig_i),
    .busy_o(busy_o), .tc_o(tc_o), .err_o(err_o), .bus_req_o(bus_req_o),
    .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o), .bus_be_o(bus_be_o),
    .bus_wdata_o(bus_wdata_o), .bus_rdata_i(rdata)
  );

  logic [15:0]   mem [256];
  int            n_rd, n_wr, tc_pulses;
  logic [AW-1:0] rd_a [8];
  logic [AW-1:0] wr_a [8];
  logic [15:0]   wr_d [8];
  logic [1:0]    wr_b [8];
  logic [3:0]    tc_seen, err_seen;
  int            total = 0, bad = 0;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] <= 16'(i * 40503) ^ 16'h5A5A;
  end

  always @(posedge clk_i) begin
    if (bus_req_o && !bus_we_o) begin
      rdata <= mem[bus_addr_o[8:1]];
      if (n_rd < 8) rd_a[n_rd] = bus_addr_o;
      n_rd++;
    end
    if (bus_req_o && bus_we_o) begin
      if (bus_be_o[0]) mem[bus_addr_o[8:1]][7:0]  <= bus_wdata_o[7:0];
      if (bus_be_o[1]) mem[bus_addr_o[8:1]][15:8] <= bus_wdata_o[15:8];
      if (n_wr < 8) begin
        wr_a[n_wr] = bus_addr_o; wr_d[n_wr] = bus_wdata_o; wr_b[n_wr] = bus_be_o;
      end
      n_wr++;
    end
    tc_seen   = tc_seen | tc_o;
    err_seen  = err_seen | err_o;
    tc_pulses = tc_pulses + $countones(tc_o);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [2:0] op, input logic [1:0] sz);
    if (op == 3'd5) return 5;
    if (sz == 2'd2) return 12;
    return 8;
  endfunction

  function automatic logic [AW-1:0] exp_step(input logic [1:0] sz);
    return (sz == 2'd0) ? AW'(1) : (sz == 2'd1) ? AW'(2) : AW'(4);
  endfunction

  task automatic clr_logs();
    n_rd = 0; n_wr = 0; tc_seen = '0; err_seen = '0; tc_pulses = 0;
  endtask

  task automatic wr_cfg(input int ch, input int sel, input logic [AW-1:0] v);
    cfg_we_i = 1'b1; cfg_ch_i = 2'(ch); cfg_sel_i = 2'(sel); cfg_wdata_i = v;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic prog(input int ch, input logic [AW-1:0] s, input logic [AW-1:0] d,
                      input int cnt, input logic [7:0] mode);
    wr_cfg(ch, 0, s); wr_cfg(ch, 1, d); wr_cfg(ch, 2, AW'(cnt)); wr_cfg(ch, 3, AW'(mode));
  endtask

  task automatic fire(input logic [3:0] m, output int cyc);
    clr_logs();
    trig_i = m;
    @(negedge clk_i);
    trig_i = '0;
    cyc = 0;
    while (busy_o) begin cyc++; @(negedge clk_i); end
    @(negedge clk_i); @(negedge clk_i);
  endtask

  task automatic wait_quiet();
    int q;
    q = 0;
    while (q < 3) begin
      @(negedge clk_i);
      if (busy_o) q = 0; else q++;
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    int cyc;
    logic [15:0] snap0, snap1;
    logic [AW-1:0] s, d, ns, nd;
    logic [2:0] op;
    logic [1:0] sz;
    int ch, cnt;
    logic [7:0] b;
    void'($urandom(32'd7));
    clr_logs();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // reset state (R10, R7, R9)
    chk("R10 reset busy", 32'(busy_o), 0);
    chk("R7 reset tc", 32'(tc_o), 0);
    chk("R9 reset err", 32'(err_o), 0);
    chk("R3 reset bus_req", 32'(bus_req_o), 0);

    // word, destination up (R1, R2, R3, R10)
    prog(0, 24'h20, 24'h80, 2, 8'h01);
    snap0 = mem[8'h10];
    fire(4'b0001, cyc);
    chk("R10 word busy", 32'(cyc), 8);
    chk("R3 word reads", 32'(n_rd), 1);
    chk("R3 word rd addr", 32'(rd_a[0]), 32'h20);
    chk("R3 word wr addr", 32'(wr_a[0]), 32'h80);
    chk("R3 word data", 32'(wr_d[0]), 32'(snap0));
    chk("R3 word lanes", 32'(wr_b[0]), 32'h3);
    chk("R7 no early tc", 32'(tc_seen), 0);
    fire(4'b0001, cyc);
    chk("R5 dst stepped", 32'(wr_a[0]), 32'h82);
    chk("R5 src held", 32'(rd_a[0]), 32'h20);
    chk("R7 tc on zero", 32'(tc_seen), 32'h1);
    chk("R7 tc one cycle", 32'(tc_pulses), 1);
    fire(4'b0001, cyc);
    chk("R8 zero count busy", 32'(cyc), 0);
    chk("R8 zero count bus", 32'(n_rd + n_wr), 0);
    chk("R8 zero count tc", 32'(tc_seen), 0);

    // 4-byte, source down (R4, R5)
    prog(1, 24'h100, 24'h30, 2, 8'h0E);
    snap0 = mem[8'h80]; snap1 = mem[8'h81];
    fire(4'b0010, cyc);
    chk("R10 quad busy", 32'(cyc), 12);
    chk("R4 quad reads", 32'(n_rd), 2);
    chk("R4 quad rd0", 32'(rd_a[0]), 32'h100);
    chk("R4 quad rd1", 32'(rd_a[1]), 32'h102);
    chk("R4 quad wr0", 32'(wr_a[0]), 32'h30);
    chk("R4 quad wr1", 32'(wr_a[1]), 32'h32);
    chk("R4 quad lo data", 32'(wr_d[0]), 32'(snap0));
    chk("R4 quad hi data", 32'(wr_d[1]), 32'(snap1));
    fire(4'b0010, cyc);
    chk("R5 src down 4", 32'(rd_a[0]), 32'hFC);

    // byte, source up, odd addresses (R3, R5)
    prog(2, 24'h41, 24'h61, 3, 8'h08);
    snap0 = mem[8'h20];
    fire(4'b0100, cyc);
    chk("R10 byte busy", 32'(cyc), 8);
    chk("R3 byte lane en", 32'(wr_b[0]), 32'h2);
    chk("R3 byte data", 32'(wr_d[0][15:8]), 32'(snap0[15:8]));
    snap0 = mem[8'h21];
    fire(4'b0100, cyc);
    chk("R5 byte src step", 32'(rd_a[0]), 32'h42);
    chk("R3 byte low lane", 32'(wr_d[0][15:8]), 32'(snap0[7:0]));

    // count-only mode (R6), then fixed (R5)
    prog(3, 24'h50, 24'h90, 3, 8'h15);
    fire(4'b1000, cyc);
    chk("R10 count busy", 32'(cyc), 5);
    chk("R6 count no bus", 32'(n_rd + n_wr), 0);
    wr_cfg(3, 3, AW'(8'h11));
    fire(4'b1000, cyc);
    chk("R6 src plus one", 32'(rd_a[0]), 32'h51);
    fire(4'b1000, cyc);
    chk("R5 fixed src", 32'(rd_a[0]), 32'h51);
    chk("R5 fixed dst", 32'(wr_a[0]), 32'h90);
    chk("R7 tc after three", 32'(tc_seen), 32'h8);

    // invalid modes (R9)
    wr_cfg(0, 2, AW'(1));
    wr_cfg(0, 3, AW'(8'h19));
    fire(4'b0001, cyc);
    chk("R9 bad op busy", 32'(cyc), 0);
    chk("R9 bad op err", 32'(err_seen), 32'h1);
    chk("R9 bad op bus", 32'(n_rd + n_wr), 0);
    wr_cfg(0, 3, AW'(8'h03));
    fire(4'b0001, cyc);
    chk("R9 bad size err", 32'(err_seen), 32'h1);
    wr_cfg(0, 3, AW'(8'h21));
    fire(4'b0001, cyc);
    chk("R9 top bits err", 32'(err_seen), 32'h1);
    wr_cfg(0, 3, AW'(8'h01));
    fire(4'b0001, cyc);
    chk("R9 count kept busy", 32'(cyc), 8);
    chk("R9 count kept tc", 32'(tc_seen), 32'h1);

    // arbitration (R11)
    for (int c = 0; c < 4; c++) prog(c, AW'(24'h140 + c * 8), AW'(24'h1C0 + c * 8), 5, 8'h11);
    clr_logs();
    trig_i = 4'b0110; @(negedge clk_i); trig_i = '0;
    wait_quiet();
    chk("R11 same cycle count", 32'(n_rd), 2);
    chk("R11 same cycle first", 32'(rd_a[0]), 32'h148);
    chk("R11 same cycle second", 32'(rd_a[1]), 32'h150);
    clr_logs();
    trig_i = 4'b0001; @(negedge clk_i); trig_i = '0;
    @(negedge clk_i); @(negedge clk_i);
    trig_i = 4'b1100; @(negedge clk_i);
    trig_i = 4'b0010; @(negedge clk_i);
    trig_i = '0;
    wait_quiet();
    chk("R11 busy latch count", 32'(n_rd), 4);
    for (int c = 0; c < 4; c++) chk("R11 busy latch order", 32'(rd_a[c]), 32'(24'h140 + c * 8));
    clr_logs();
    trig_i = 4'b0001; @(negedge clk_i); trig_i = '0;
    @(negedge clk_i); trig_i = 4'b0100; @(negedge clk_i); trig_i = '0;
    @(negedge clk_i); trig_i = 4'b0100; @(negedge clk_i); trig_i = '0;
    wait_quiet();
    chk("R11 merge count", 32'(n_rd), 2);
    chk("R11 merge channel", 32'(rd_a[1]), 32'h150);

    // constrained random (R3, R5, R7, R8, R10)
    for (int it = 0; it < 30; it++) begin
      ch  = int'($urandom_range(0, 3));
      op  = 3'($urandom_range(0, 5));
      sz  = 2'($urandom_range(0, 2));
      cnt = int'($urandom_range(1, 2));
      s   = AW'($urandom_range(16, 200) * 2);
      d   = AW'($urandom_range(16, 200) * 2);
      if (sz == 2'd2) begin s[1] = 1'b0; d[1] = 1'b0; end
      if (sz == 2'd0) begin s[0] = 1'($urandom_range(0, 1)); d[0] = 1'($urandom_range(0, 1)); end
      prog(ch, s, d, cnt, {3'b000, op, sz});
      snap0 = mem[s[8:1]]; snap1 = mem[s[8:1] + 8'd1];
      fire(4'(1 << ch), cyc);
      chk("R10 rand busy", 32'(cyc), 32'(exp_len(op, sz)));
      if (op == 3'd5) begin
        chk("R6 rand no bus", 32'(n_rd + n_wr), 0);
      end else begin
        chk("R3 rand rd addr", 32'(rd_a[0]), 32'(s));
        chk("R3 rand wr addr", 32'(wr_a[0]), 32'(d));
        if (sz == 2'd0) begin
          b = s[0] ? snap0[15:8] : snap0[7:0];
          chk("R3 rand byte data", 32'(wr_d[0]), 32'({b, b}));
          chk("R3 rand byte lane", 32'(wr_b[0]), d[0] ? 32'h2 : 32'h1);
        end else begin
          chk("R3 rand data", 32'(wr_d[0]), 32'(snap0));
          if (sz == 2'd2) chk("R4 rand hi data", 32'(wr_d[1]), 32'(snap1));
        end
      end
      chk("R7 rand tc", 32'(tc_seen), (cnt == 1) ? 32'(1 << ch) : 0);
      ns = s; nd = d;
      case (op)
        3'd0: nd = d + exp_step(sz);
        3'd1: nd = d - exp_step(sz);
        3'd2: ns = s + exp_step(sz);
        3'd3: ns = s - exp_step(sz);
        3'd5: ns = s + AW'(1);
        default: ;
      endcase
      if (op == 3'd5) wr_cfg(ch, 3, AW'({3'b000, 3'd4, 2'd1}));
      fire(4'(1 << ch), cyc);
      if (cnt == 1) begin
        chk("R8 rand drained", 32'(cyc), 0);
      end else begin
        chk("R5 rand next src", 32'(rd_a[0]), 32'(ns));
        chk("R5 rand next dst", 32'(wr_a[0]), 32'(nd));
      end
    end

    finish_run();
  end
endmodule